// File: doc/BRIEF.md
# Signed Packed-Decimal Add/Subtract Unit

This unit adds or subtracts two signed packed-decimal words of 128 bits. Each word carries 31 decimal digits, four bits per digit, above a four-bit sign code in the lowest nibble. The unit returns a packed-decimal word of the same shape and a four-bit condition field.

The condition field reports the sign of the exact result, as if it had no digit limit. It also reports whether that result needed a 32nd digit. When it did, the returned word keeps only the low 31 digits. A carry that leaves every kept digit zero therefore still reports greater-than or less-than, with the overflow bit set as well. A preferred-sign input chooses which of the two positive sign codes is written.

The operands are checked for valid encoding. Any bad operand turns the condition field into a lone overflow flag. Operations are issued with a one-cycle start strobe, and a new one may be issued on every clock. Each result appears, registered, in the cycle after its start.

Top module: `bcd_arith_unit`

## Requirements
- R1: `done` is high in exactly the cycle after `start` was sampled high. A start is accepted on every cycle. `result` and `cond` keep their last values while no start is sampled.
- R2: An operand holds digit k (k = 0 is least significant) at bits [4k+7:4k+4] and its sign code at bits [3:0]. Sign codes 4'hA, 4'hC, 4'hE and 4'hF are positive. Codes 4'hB and 4'hD are negative.
- R3: A sign code of 4'h0 to 4'h9 in either operand, or a digit above 9 in either operand, makes `cond` equal 4'b0001. The result word is then not defined.
- R4: Subtraction (`op_sub`=1) is addition with B's sign inverted. When the effective signs agree, the magnitudes are added and the common sign is kept.
- R5: When the effective signs differ, the smaller magnitude is taken from the larger one and the result takes the sign of the larger. This path never sets the overflow bit.
- R6: A positive result carries sign code 4'hC when `pref_sign`=0 and 4'hF when `pref_sign`=1. A negative result carries 4'hD.
- R7: `cond` encodes less-than as 4'b1000, greater-than as 4'b0100, equal-to-zero as 4'b0010 and overflow as 4'b0001. A nonzero positive exact result gives greater-than and a negative one gives less-than.
- R8: A carry out of the 31st digit sets the overflow bit together with greater-than or less-than, and only the low 31 digits are kept. For example, the largest positive value minus negative one gives positive zero with `cond`=4'b0101.
- R9: An exact result of zero, including negative zero plus negative zero and equal magnitudes of opposite sign, is returned as all-zero digits with the preferred positive sign code, and `cond`=4'b0010.
- R10: While `rst_n` is low, `done`, `result` and `cond` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue strobe for one operation |
| op_sub | input | 1 | 1 = A minus B, 0 = A plus B |
| opa | input | 128 | Operand A, signed packed decimal |
| opb | input | 128 | Operand B, signed packed decimal |
| pref_sign | input | 1 | Selects positive sign code 4'hF (1) or 4'hC (0) |
| done | output | 1 | Result valid strobe |
| result | output | 128 | Signed packed-decimal result |
| cond | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The assertions check on every cycle the issue-to-done timing and the legal set of condition codes. They also check that the sign nibble agrees with the reported sign and the preferred-sign choice, that a zero report comes with all-zero digits, and that the internal invalid and carry events reach the condition field one cycle later. Only the bench's scenarios can show the digit values themselves. This covers decimal carries and borrows between digits, the choice of the larger magnitude, truncation to 31 digits on overflow, and the effect of each sign code and operation select on the final word.

// File: rtl/bcd_arith_pkg.sv
package bcd_arith_pkg;
  parameter int NDIG = 31;
  localparam int MAGW  = NDIG * 4;
  localparam int WORDW = MAGW + 4;

  localparam logic [3:0] SGN_POS_STD = 4'hC;
  localparam logic [3:0] SGN_POS_ALT = 4'hF;
  localparam logic [3:0] SGN_NEG     = 4'hD;

  localparam logic [3:0] CF_LT = 4'b1000;
  localparam logic [3:0] CF_GT = 4'b0100;
  localparam logic [3:0] CF_EQ = 4'b0010;
  localparam logic [3:0] CF_SO = 4'b0001;

  // Digit-serial decimal sum; top bit is the carry out of the last digit.
  function automatic logic [MAGW:0] dec_add(input logic [MAGW-1:0] x, input logic [MAGW-1:0] y);
    logic       cy;
    logic [4:0] s;
    logic [MAGW-1:0] r;
    cy = 1'b0;
    r  = '0;
    for (int i = 0; i < NDIG; i++) begin
      s = {1'b0, x[i*4 +: 4]} + {1'b0, y[i*4 +: 4]} + {4'd0, cy};
      if (s > 5'd9) begin
        s  = s - 5'd10;
        cy = 1'b1;
      end else begin
        cy = 1'b0;
      end
      r[i*4 +: 4] = s[3:0];
    end
    return {cy, r};
  endfunction

  // Decimal difference x - y, caller guarantees x >= y.
  function automatic logic [MAGW-1:0] dec_sub(input logic [MAGW-1:0] x, input logic [MAGW-1:0] y);
    logic       bw;
    logic [4:0] s;
    logic [MAGW-1:0] r;
    bw = 1'b0;
    r  = '0;
    for (int i = 0; i < NDIG; i++) begin
      s = {1'b0, x[i*4 +: 4]} - {1'b0, y[i*4 +: 4]} - {4'd0, bw};
      if (s[4]) begin
        s  = s + 5'd10;
        bw = 1'b1;
      end else begin
        bw = 1'b0;
      end
      r[i*4 +: 4] = s[3:0];
    end
    return r;
  endfunction
endpackage

// File: rtl/bcd_sign_decode.sv
module bcd_sign_decode (
  input  logic [3:0] code,
  output logic       ok,
  output logic       neg
);
  always_comb begin
    ok  = 1'b1;
    neg = 1'b0;
    case (code)
      4'hA, 4'hC, 4'hE, 4'hF: neg = 1'b0;
      4'hB, 4'hD:             neg = 1'b1;
      default:                ok  = 1'b0;
    endcase
  end
endmodule

// File: rtl/bcd_digit_check.sv
module bcd_digit_check #(
  parameter int NDIG = 31,
  localparam int MAGW = NDIG * 4
) (
  input  logic [MAGW-1:0] mag,
  output logic            ok
);
  logic [NDIG-1:0] dig_ok;
  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    assign dig_ok[g] = (mag[g*4 +: 4] <= 4'd9);
  end
  assign ok = &dig_ok;
endmodule

// File: rtl/bcd_mag_core.sv
module bcd_mag_core
  import bcd_arith_pkg::*;
(
  input  logic [MAGW-1:0]  mag_a,
  input  logic [MAGW-1:0]  mag_b,
  input  logic             neg_a,
  input  logic             neg_b,
  input  logic             pref,
  output logic [WORDW-1:0] res,
  output logic [3:0]       flags,
  output logic             ovf,
  output logic             zero
);
  logic            same_sgn, a_ge, neg_r;
  logic [MAGW:0]   sum_w;
  logic [MAGW-1:0] diff_w, mag_r;
  logic [3:0]      pos_code;

  assign same_sgn = (neg_a == neg_b);
  assign sum_w    = dec_add(mag_a, mag_b);
  assign a_ge     = (mag_a >= mag_b);
  assign diff_w   = a_ge ? dec_sub(mag_a, mag_b) : dec_sub(mag_b, mag_a);
  assign pos_code = pref ? SGN_POS_ALT : SGN_POS_STD;

  always_comb begin
    if (same_sgn) begin
      mag_r = sum_w[MAGW-1:0];
      ovf   = sum_w[MAGW];
      zero  = !sum_w[MAGW] && (sum_w[MAGW-1:0] == '0);
      neg_r = neg_a;
    end else begin
      mag_r = diff_w;
      ovf   = 1'b0;
      zero  = (mag_a == mag_b);
      neg_r = a_ge ? neg_a : neg_b;
    end
    if (zero) begin
      res   = {{MAGW{1'b0}}, pos_code};
      flags = CF_EQ;
    end else begin
      res   = {mag_r, (neg_r ? SGN_NEG : pos_code)};
      flags = (neg_r ? CF_LT : CF_GT) | (ovf ? CF_SO : 4'b0000);
    end
  end
endmodule

// File: rtl/bcd_arith_unit.sv
module bcd_arith_unit
  import bcd_arith_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               op_sub,
  input  logic [WORDW-1:0]   opa,
  input  logic [WORDW-1:0]   opb,
  input  logic               pref_sign,
  output logic               done,
  output logic [WORDW-1:0]   result,
  output logic [3:0]         cond
);
  logic sa_ok, sa_neg, sb_ok, sb_neg, da_ok, db_ok;
  logic invalid_w, ovf_w, zero_w;
  logic [WORDW-1:0] core_res;
  logic [3:0]       core_flags;

  bcd_sign_decode u_sa (.code(opa[3:0]), .ok(sa_ok), .neg(sa_neg));
  bcd_sign_decode u_sb (.code(opb[3:0]), .ok(sb_ok), .neg(sb_neg));
  bcd_digit_check #(.NDIG(NDIG)) u_da (.mag(opa[WORDW-1:4]), .ok(da_ok));
  bcd_digit_check #(.NDIG(NDIG)) u_db (.mag(opb[WORDW-1:4]), .ok(db_ok));

  assign invalid_w = !(sa_ok && sb_ok && da_ok && db_ok);

  bcd_mag_core u_core (
    .mag_a(opa[WORDW-1:4]), .mag_b(opb[WORDW-1:4]),
    .neg_a(sa_neg), .neg_b(sb_neg ^ op_sub), .pref(pref_sign),
    .res(core_res), .flags(core_flags), .ovf(ovf_w), .zero(zero_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done   <= 1'b0;
      result <= '0;
      cond   <= 4'b0000;
    end else begin
      done <= start;
      if (start) begin
        result <= invalid_w ? '0 : core_res;
        cond   <= invalid_w ? CF_SO : core_flags;
      end
    end
  end
endmodule

// File: rtl/bcd_arith_chk.sv
module bcd_arith_chk
  import bcd_arith_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             pref_sign,
  input logic             done,
  input logic [WORDW-1:0] result,
  input logic [3:0]       cond,
  input logic             invalid_w,
  input logic             ovf_w
);
  assert_done_follows_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  assert_done_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(result) && $stable(cond)));
  assert_cond_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cond == CF_EQ || cond == CF_GT || cond == CF_LT || cond == CF_SO ||
              cond == (CF_GT | CF_SO) || cond == (CF_LT | CF_SO)));
  assert_neg_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cond[3]) |-> result[3:0] == SGN_NEG);
  assert_pos_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cond[2]) |-> result[3:0] == ($past(pref_sign) ? SGN_POS_ALT : SGN_POS_STD));
  assert_zero_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cond == CF_EQ) |-> (result[WORDW-1:4] == '0 &&
      result[3:0] == ($past(pref_sign) ? SGN_POS_ALT : SGN_POS_STD)));
  assert_invalid_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && invalid_w) |=> cond == CF_SO);
  assert_overflow_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !invalid_w && ovf_w) |=> (cond[0] && $onehot(cond[3:2])));
endmodule

bind bcd_arith_unit bcd_arith_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .pref_sign(pref_sign),
  .done(done), .result(result), .cond(cond),
  .invalid_w(invalid_w), .ovf_w(ovf_w)
);

// File: tb/sim_bcd_arith_unit.sv
`timescale 1ns/1ps
module sim_bcd_arith_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         op_sub = 1'b0;
  logic [127:0] opa = '0;
  logic [127:0] opb = '0;
  logic         pref_sign = 1'b0;
  logic         done;
  logic [127:0] result;
  logic [3:0]   cond;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bcd_arith_unit u0 (.clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub),
    .opa(opa), .opb(opb), .pref_sign(pref_sign), .done(done), .result(result), .cond(cond));

  typedef struct packed {
    logic         sub;
    logic [127:0] a;
    logic [127:0] b;
    logic         ps;
    logic [127:0] r;
    logic [3:0]   c;
    logic         chk_r;
  } vec_t;

  localparam logic [123:0] NINES = {31{4'h9}};
  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    // R8: max positive minus negative one -> positive zero, GT|SO
    '{1'b1, {NINES,4'hC}, 128'h1D, 1'b0, 128'hC, 4'b0101, 1'b1},
    '{1'b1, {NINES,4'hC}, 128'h1D, 1'b1, 128'hF, 4'b0101, 1'b1},
    // R4/R6: ...98 minus -1 -> max positive, GT
    '{1'b1, {NINES[123:4],4'h8,4'hC}, 128'h1D, 1'b0, {NINES,4'hC}, 4'b0100, 1'b1},
    '{1'b1, {NINES[123:4],4'h8,4'hC}, 128'h1D, 1'b1, {NINES,4'hF}, 4'b0100, 1'b1},
    // R9: equal operands subtracted
    '{1'b1, {NINES,4'hC}, {NINES,4'hC}, 1'b0, 128'hC, 4'b0010, 1'b1},
    '{1'b1, {NINES,4'hC}, {NINES,4'hC}, 1'b1, 128'hF, 4'b0010, 1'b1},
    // R5: 0 - 1 -> -1, LT
    '{1'b1, 128'hC, 128'h1C, 1'b0, 128'h1D, 4'b1000, 1'b1},
    // R8: max negative minus one -> negative zero digits, LT|SO
    '{1'b1, {NINES,4'hD}, 128'h1C, 1'b1, 128'hD, 4'b1001, 1'b1},
    // R4: plain add, and decimal carry between digits
    '{1'b0, 128'h123C, 128'h456C, 1'b0, 128'h579C, 4'b0100, 1'b1},
    '{1'b0, 128'h19C, 128'h1C, 1'b0, 128'h20C, 4'b0100, 1'b1},
    // R2/R5: -100 + 1 (sign A positive) -> -99
    '{1'b0, 128'h100D, 128'h1A, 1'b0, 128'h99D, 4'b1000, 1'b1},
    // R9: -5 (sign B) + 5 (sign E) -> +0
    '{1'b0, 128'h5B, 128'h5E, 1'b0, 128'hC, 4'b0010, 1'b1},
    // R9: -0 + -0 -> +0 preferred F
    '{1'b0, 128'hD, 128'hD, 1'b1, 128'hF, 4'b0010, 1'b1},
    // R3: bad sign nibble, bad digit
    '{1'b1, 128'h1C, 128'hF00, 1'b0, 128'h0, 4'b0001, 1'b0},
    '{1'b0, 128'hBAD, 128'h1C, 1'b1, 128'h0, 4'b0001, 1'b0},
    // R5: 25 - 7 with borrow -> 18
    '{1'b1, 128'h25C, 128'h7C, 1'b0, 128'h18C, 4'b0100, 1'b1}
  };

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 done", {127'd0, done}, 128'd0);
    chk("R10 result", result, 128'd0);
    chk("R10 cond", {124'd0, cond}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle done", {127'd0, done}, 128'd0);

    // back-to-back issue, one vector per cycle
    for (int i = 0; i < NV; i++) begin
      start = 1'b1; op_sub = VECS[i].sub; opa = VECS[i].a; opb = VECS[i].b;
      pref_sign = VECS[i].ps;
      @(negedge clk);
      chk("R1 done", {127'd0, done}, 128'd1);
      chk("R7 cond", {124'd0, cond}, {124'd0, VECS[i].c});
      if (VECS[i].chk_r) chk("R4 result", result, VECS[i].r);
    end

    // idle: done drops, outputs hold although inputs change
    start = 1'b0; opa = 128'h1C; opb = 128'h1C; op_sub = 1'b0;
    @(negedge clk);
    chk("R1 done low", {127'd0, done}, 128'd0);
    chk("R1 hold result", result, 128'h18C);
    chk("R1 hold cond", {124'd0, cond}, 128'h4);

    // R3: invalid sign in A alone
    start = 1'b1; opa = 128'hF00; opb = 128'h1C; op_sub = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R3 cond", {124'd0, cond}, 128'h1);

    // R8: max + max -> 31 digits of ...98, GT|SO
    start = 1'b1; op_sub = 1'b0; opa = {NINES,4'hC}; opb = {NINES,4'hC}; pref_sign = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk("R8 result", result, {NINES[123:4],4'h8,4'hC});
    chk("R8 cond", {124'd0, cond}, 128'h5);

    // R10: reset clears the outputs
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 reset result", result, 128'd0);
    chk("R10 reset cond", {124'd0, cond}, 128'd0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule